// File: doc/BRIEF.md
# Comparison-Free Counting Sorter

This block puts a stream of unsigned integer keys into ascending order without ever comparing one key with another. A sort is framed by a start pulse. After one clearing cycle the block accepts keys, at most one per clock, on a valid/ready input. Each accepted key is decoded to a one-hot position in a row of occurrence counters, one counter for every possible key value, and that counter is incremented. The position of the counter is the ordering information, so no compare-exchange step exists anywhere in the path.

When loading ends, the block walks the key values from zero upward. For each value whose counter is nonzero, it emits that value on a valid/ready output stream as many times as it was loaded. The output stalls cleanly under backpressure. A one-cycle done pulse closes the sort. Key width and the maximum element count per sort are parameters. Every counter is sized to hold the full element count. The total time is one cycle per key for loading, plus at most one scan cycle per key value, plus one cycle per emitted element. It therefore grows linearly with the element count.

The controller is a state machine with these states:
- `ST_IDLE`: waiting for start.
- `ST_CLEAR`: zeroing the counters.
- `ST_LOAD`: accepting keys.
- `ST_SCAN`: looking at one counter per cycle.
- `ST_EMIT`: presenting one value until all its copies are taken.
- `ST_DONE`: the one-cycle completion state.

Its transitions are:
- idle to clear on start.
- clear to load, unconditionally.
- load to scan on an accepted key that is flagged last or that fills the element limit.
- scan to emit on a nonzero counter; otherwise scan stays in scan and the value index advances.
- emit to done when the final element is taken.
- emit to scan when the last copy of the current value is taken.
- done to idle, unconditionally.

Top module: `count_sorter`

## Requirements
- R1: After reset, busy_o, done_o, in_ready_o and out_valid_o are all low.
- R2: A start_i pulse sampled while idle causes one clearing cycle, with busy_o high and in_ready_o low, and then in_ready_o is high from the second cycle after the edge that sampled start_i.
- R3: Each counter holds MAX_N. Loading ends by itself at the edge that accepts the MAX_N-th key, after which in_ready_o is low. A single value loaded MAX_N times is emitted MAX_N times.
- R4: Loading ends at the edge that accepts a key with in_last_i high, and in_ready_o is low in the following cycle.
- R5: Output keys appear in ascending numeric order. Each value is emitted exactly as often as it was accepted, and values never loaded are not emitted.
- R6: While out_valid_o is high and out_ready_i is low, out_valid_o stays high and out_key_o keeps its value in the next cycle.
- R7: done_o is high for exactly one cycle, the cycle right after the edge that transfers the final output element. busy_o is low in the following cycle.
- R8: A start_i pulse during loading or emitting has no effect: the sort in progress finishes with the correct output, and no new sort begins after it.
- R9: All counters are zero at the start of every load phase, so keys from an earlier sort never appear in a later one.
- R10: Keys offered while the block is not loading are not accepted (in_ready_o low) and do not appear in the next sort's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to begin a new sort; honoured only when idle |
| busy_o | output | 1 | High from the clearing cycle through the done cycle |
| done_o | output | 1 | One-cycle pulse after the final element is transferred |
| in_valid_i | input | 1 | Input key is valid |
| in_ready_o | output | 1 | Block accepts a key this cycle (load phase only) |
| in_key_i | input | KEY_W | Unsigned input key |
| in_last_i | input | 1 | The accompanying key is the final one of this sort |
| out_valid_o | output | 1 | Output key is valid |
| out_ready_i | input | 1 | Downstream takes the output key this cycle |
| out_key_o | output | KEY_W | Sorted output key |

## Verification
The assertions take for granted three things about the environment. It raises start_i only to begin a sort. It marks the end of a load with in_last_i or by reaching MAX_N keys. It never offers more than MAX_N keys to one sort, which is what makes the overflow property on the element and occurrence counts hold. The stimulus keeps within these assumptions: every load phase is at most MAX_N keys long, and exactly one of the two ending conditions is used in each case. Extra start pulses and keys outside the load phase are applied on purpose, because the design must ignore them.

// File: rtl/csort_pkg.sv
package csort_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_LOAD,
        ST_SCAN,
        ST_EMIT,
        ST_DONE
    } sort_state_t;

endpackage

// File: rtl/key_onehot.sv
module key_onehot #(
    parameter int KEY_W = 10,
    localparam int VALS = 1 << KEY_W
) (
    input  logic             en_i,
    input  logic [KEY_W-1:0] key_i,
    output logic [VALS-1:0]  hit_o
);

    // Position decode: each output line stands for one key value.
    for (genvar g = 0; g < VALS; g++) begin : g_line
        assign hit_o[g] = en_i && (key_i == KEY_W'(g));
    end

endmodule

// File: rtl/occ_bank.sv
module occ_bank #(
    parameter int KEY_W = 10,
    parameter int MAX_N = 1024,
    localparam int VALS  = 1 << KEY_W,
    localparam int CNT_W = $clog2(MAX_N + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic [VALS-1:0]  hit_i,
    input  logic [KEY_W-1:0] rd_idx_i,
    output logic [CNT_W-1:0] rd_cnt_o
);

    logic [CNT_W-1:0] cnt_q [VALS];

    for (genvar g = 0; g < VALS; g++) begin : g_cnt
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_q[g] <= '0;
            end else if (clr_i) begin
                cnt_q[g] <= '0;
            end else if (hit_i[g]) begin
                cnt_q[g] <= cnt_q[g] + 1'b1;
            end
        end

        // R3: a counter is never bumped past the per-sort element limit
        assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
            hit_i[g] |-> (cnt_q[g] < CNT_W'(MAX_N)));
    end

    assign rd_cnt_o = cnt_q[rd_idx_i];

endmodule

// File: rtl/sort_ctrl.sv
module sort_ctrl
    import csort_pkg::*;
#(
    parameter int KEY_W = 10,
    parameter int MAX_N = 1024,
    localparam int CNT_W = $clog2(MAX_N + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             in_valid_i,
    input  logic             in_last_i,
    input  logic             out_ready_i,
    input  logic [CNT_W-1:0] rd_cnt_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             in_ready_o,
    output logic             out_valid_o,
    output logic             clr_o,
    output logic             inc_en_o,
    output logic [KEY_W-1:0] idx_o
);

    sort_state_t      state_q, state_d;
    logic [KEY_W-1:0] idx_q;
    logic [CNT_W-1:0] rem_q;
    logic [CNT_W-1:0] left_q;
    logic             load_fire, out_fire, load_full;

    assign load_fire = (state_q == ST_LOAD) && in_valid_i;
    assign out_fire  = (state_q == ST_EMIT) && out_ready_i;
    assign load_full = (left_q == CNT_W'(MAX_N - 1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_CLEAR;
            ST_CLEAR: state_d = ST_LOAD;
            ST_LOAD:  if (load_fire && (in_last_i || load_full)) state_d = ST_SCAN;
            ST_SCAN:  if (rd_cnt_i != '0) state_d = ST_EMIT;
            ST_EMIT: begin
                if (out_fire && left_q == CNT_W'(1))     state_d = ST_DONE;
                else if (out_fire && rem_q == CNT_W'(1)) state_d = ST_SCAN;
            end
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            rem_q  <= '0;
            left_q <= '0;
        end else begin
            unique case (state_q)
                ST_CLEAR: begin
                    idx_q  <= '0;
                    rem_q  <= '0;
                    left_q <= '0;
                end
                ST_LOAD: if (load_fire) left_q <= left_q + 1'b1;
                ST_SCAN: begin
                    if (rd_cnt_i != '0) rem_q <= rd_cnt_i;
                    else                idx_q <= idx_q + 1'b1;
                end
                ST_EMIT: if (out_fire) begin
                    left_q <= left_q - 1'b1;
                    rem_q  <= rem_q - 1'b1;
                    if (rem_q == CNT_W'(1)) idx_q <= idx_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        busy_o      = (state_q != ST_IDLE);
        done_o      = (state_q == ST_DONE);
        in_ready_o  = (state_q == ST_LOAD);
        out_valid_o = (state_q == ST_EMIT);
        clr_o       = (state_q == ST_CLEAR);
        inc_en_o    = load_fire;
        idx_o       = idx_q;
    end

    // R3: the element tally never exceeds its limit
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load_fire |-> (left_q < CNT_W'(MAX_N)));

    // R5: successive transferred keys never decrease within one emit run
    assert_ascending_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && out_ready_i) |=> (!out_valid_o || idx_o >= $past(idx_o)));

    // R6: a stalled output holds
    assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(idx_o)));

    // R7: done lasts one cycle and follows a transfer
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_done_after_emit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(out_valid_o && out_ready_i));

    // R8: start during a running sort never restarts it
    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && (in_ready_o || out_valid_o)) |=> (state_q != ST_CLEAR));

endmodule

// File: rtl/count_sorter.sv
module count_sorter #(
    parameter int KEY_W = 10,
    parameter int MAX_N = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic             busy_o,
    output logic             done_o,
    input  logic             in_valid_i,
    output logic             in_ready_o,
    input  logic [KEY_W-1:0] in_key_i,
    input  logic             in_last_i,
    output logic             out_valid_o,
    input  logic             out_ready_i,
    output logic [KEY_W-1:0] out_key_o
);

    localparam int VALS  = 1 << KEY_W;
    localparam int CNT_W = $clog2(MAX_N + 1);

    logic             clr, inc_en;
    logic [VALS-1:0]  hit;
    logic [KEY_W-1:0] idx;
    logic [CNT_W-1:0] rd_cnt;

    sort_ctrl #(.KEY_W(KEY_W), .MAX_N(MAX_N)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .in_valid_i (in_valid_i),
        .in_last_i  (in_last_i),
        .out_ready_i(out_ready_i),
        .rd_cnt_i   (rd_cnt),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .in_ready_o (in_ready_o),
        .out_valid_o(out_valid_o),
        .clr_o      (clr),
        .inc_en_o   (inc_en),
        .idx_o      (idx)
    );

    key_onehot #(.KEY_W(KEY_W)) u_dec (
        .en_i (inc_en),
        .key_i(in_key_i),
        .hit_o(hit)
    );

    occ_bank #(.KEY_W(KEY_W), .MAX_N(MAX_N)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr),
        .hit_i   (hit),
        .rd_idx_i(idx),
        .rd_cnt_o(rd_cnt)
    );

    assign out_key_o = idx;

endmodule

// File: tb/count_sorter_test.sv
module count_sorter_test;

    localparam int CLK_PERIOD = 10;
    localparam int KEY_W = 3;
    localparam int MAX_N = 12;
    localparam int NCASE = 5;
    localparam int LMAX  = 8;
    // case table: keys, length, backpressure mode, start-poke phase (0 none, 1 load, 2 emit)
    localparam int VEC [NCASE][LMAX] = '{
        '{3, 1, 4, 1, 5, 1, 2, 6},
        '{7, 7, 7, 0, 0, 7, 3, 3},
        '{0, 1, 2, 3, 4, 5, 6, 7},
        '{7, 6, 5, 4, 3, 2, 1, 0},
        '{5, 0, 0, 0, 0, 0, 0, 0}
    };
    localparam int VLEN [NCASE] = '{8, 6, 8, 8, 1};
    localparam int MODE [NCASE] = '{0, 1, 2, 3, 1};
    localparam int POKE [NCASE] = '{0, 1, 2, 0, 0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic busy_o, done_o;
    logic in_valid_i = 1'b0;
    logic in_ready_o;
    logic [KEY_W-1:0] in_key_i = '0;
    logic in_last_i = 1'b0;
    logic out_valid_o;
    logic out_ready_i = 1'b0;
    logic [KEY_W-1:0] out_key_o;

    int checks = 0;
    int failures = 0;
    int cur_keys [16];
    int cur_n;
    bit use_last;
    int mode;
    int poke;

    always #(CLK_PERIOD / 2) clk = ~clk;

    count_sorter #(.KEY_W(KEY_W), .MAX_N(MAX_N)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
        .in_valid_i(in_valid_i), .in_ready_o(in_ready_o), .in_key_i(in_key_i),
        .in_last_i(in_last_i), .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
        .out_key_o(out_key_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit rdy_pattern(input int m, input int c);
        case (m)
            0: return 1'b1;
            1: return (c % 2) == 0;
            2: return (c % 3) == 2;
            default: return (c % 4) != 1;
        endcase
    endfunction

    task automatic sort_and_check();
        int exp [16];
        int got, cyc, i, t, fire_cyc, done_cyc, done_cnt, prev_key;
        bit prev_stall;
        // reference order by insertion sort
        for (int a = 0; a < cur_n; a++) exp[a] = cur_keys[a];
        for (int a = 1; a < cur_n; a++) begin
            t = exp[a];
            i = a - 1;
            while (i >= 0 && exp[i] > t) begin
                exp[i + 1] = exp[i];
                i--;
            end
            exp[i + 1] = t;
        end
        // start and clear cycle
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        check(busy_o && !in_ready_o, "R2 clear cycle busy/in_ready", {busy_o, in_ready_o}, 2);
        @(negedge clk);
        check(in_ready_o, "R2 in_ready after clear", in_ready_o, 1);
        // load phase
        i = 0;
        cyc = 0;
        while (i < cur_n && cyc < 100) begin
            check(in_ready_o, "R4 in_ready during load", in_ready_o, 1);
            start_i = (poke == 1 && i == 2);
            if ((mode % 2) == 1 && (cyc % 3) == 1) begin
                in_valid_i = 1'b0;
            end else begin
                in_valid_i = 1'b1;
                in_key_i   = KEY_W'(cur_keys[i]);
                in_last_i  = use_last && (i == cur_n - 1);
                i++;
            end
            cyc++;
            @(negedge clk);
        end
        in_valid_i = 1'b0;
        in_last_i  = 1'b0;
        start_i    = 1'b0;
        if (use_last) check(!in_ready_o, "R4 load ends on last", in_ready_o, 0);
        else          check(!in_ready_o, "R3 load ends at MAX_N", in_ready_o, 0);
        // emit phase
        got = 0;
        cyc = 0;
        fire_cyc = -10;
        done_cyc = -1;
        done_cnt = 0;
        prev_stall = 1'b0;
        prev_key = 0;
        while (cyc < 400 && done_cnt == 0) begin
            out_ready_i = rdy_pattern(mode, cyc);
            start_i = (poke == 2 && got == 1);
            if (prev_stall)
                check(out_valid_o && out_key_o == KEY_W'(prev_key), "R6 hold under stall",
                      int'(out_key_o), prev_key);
            if (done_o) begin
                done_cnt++;
                done_cyc = cyc;
            end else if (out_valid_o && out_ready_i) begin
                if (got < cur_n)
                    check(int'(out_key_o) == exp[got], "R5 output order/value",
                          int'(out_key_o), exp[got]);
                else
                    check(1'b0, "R5 extra output", got + 1, cur_n);
                got++;
                fire_cyc = cyc;
            end
            prev_stall = out_valid_o && !out_ready_i;
            prev_key = int'(out_key_o);
            cyc++;
            @(negedge clk);
        end
        out_ready_i = 1'b0;
        start_i = 1'b0;
        check(got == cur_n, "R5 output count", got, cur_n);
        check(done_cyc == fire_cyc + 1, "R7 done follows final transfer", done_cyc, fire_cyc + 1);
        check(!done_o, "R7 done one cycle", done_o, 0);
        check(!busy_o, "R7 busy low after done", busy_o, 0);
        @(negedge clk);
        check(!busy_o && !out_valid_o, "R8 no restart after ignored start", busy_o, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !done_o && !in_ready_o && !out_valid_o, "R1 reset state",
              {busy_o, done_o, in_ready_o, out_valid_o}, 0);

        // table-driven sorts (R9 also covered: each case follows a different one)
        for (int c = 0; c < NCASE; c++) begin
            cur_n = VLEN[c];
            for (int k = 0; k < LMAX; k++) cur_keys[k] = VEC[c][k];
            use_last = 1'b1;
            mode = MODE[c];
            poke = POKE[c];
            sort_and_check();
        end

        // R10: keys offered while idle are refused and do not leak into the next sort
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            in_valid_i = 1'b1;
            in_key_i = 3'd6;
            check(!in_ready_o, "R10 in_ready low when idle", in_ready_o, 0);
        end
        @(negedge clk) in_valid_i = 1'b0;
        cur_n = 2;
        cur_keys[0] = 2;
        cur_keys[1] = 2;
        use_last = 1'b1;
        mode = 0;
        poke = 0;
        sort_and_check();  // R9/R10: exactly 2,2 expected

        // R3: MAX_N copies of the top value, no last flag
        cur_n = MAX_N;
        for (int k = 0; k < MAX_N; k++) cur_keys[k] = 7;
        use_last = 1'b0;
        mode = 1;
        poke = 0;
        sort_and_check();

        // R3: MAX_N copies of the bottom value, always ready
        for (int k = 0; k < MAX_N; k++) cur_keys[k] = 0;
        mode = 0;
        sort_and_check();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule